// File: doc/BRIEF.md
# Dual-Issue Instruction Pair Scheduler

This block sits at the issue point of a two-wide, in-order, five-stage 32-bit pipeline. Each cycle fetch presents two instruction words: the leading word at the current fetch address and the trailing word at that address plus 4. The scheduler decodes both words and decides whether the trailing word may issue alongside the leading one. If it may not, way 2 receives the all-zero NOP word with its valid bit cleared. The fetch address then steps by only 4, so the displaced word becomes the leading word of the next pair. When every pair conflicts, throughput falls to one instruction per cycle.

The issued words, their valid bits and a dual-issue flag are registered and appear one clock after the pair is presented. The next fetch address is combinational, so fetch can use it in the same cycle.

A two-state machine governs issue:
- RUN is the normal state.
- HALTED is entered when a halt word issues on way 1. HALTED issues nothing and holds the fetch address until reset.
- There are two transitions: RUN to HALTED on an issued halt, and any state to RUN on reset.

Top module: `pair_scheduler`

## Requirements
- R1: Reset behaviour. During and after reset, both valid bits, both issued words and `pair_dual` are 0, and `halted` is 0 (state RUN). With `fetch_valid` low, `next_pc` equals `fetch_pc`.
- R2: Independent pair. In RUN with `fetch_valid` high, when no rule below applies, the clock edge sets `way1_word`/`way2_word` to the two slots, sets both valid bits and `pair_dual` to 1, and makes `next_pc` = `fetch_pc`+8.
- R3: Read-after-write. A split occurs when the trailing word reads a register the leading word writes. A split means `way2_valid`=0, `pair_dual`=0 and `next_pc` = `fetch_pc`+4. Registers read by each instruction:
  - R-type (opcode 0) reads rs [25:21] and rt [20:16].
  - addi (0x08) and lw (0x23) read rs.
  - sw (0x2B) and beq (0x04) read rs and rt.
  - jr (opcode 0, funct 0x08) reads rs.
  - j (0x02) and jal (0x03) read nothing.
- R4: Write-after-write. A split occurs when both words write the same register. Destination registers:
  - R-type writes rd [15:11].
  - addi and lw write rt.
  - jal writes register 31.
  - sw, beq, j, jr and halt write nothing.
- R5: A write to register 0 never causes a split, whether as RAW or WAW.
- R6: A control transfer (beq, j, jal, jr) in slot 2 causes a split.
- R7: A control transfer in slot 1 issues alone. Way 2 gets the NOP and `next_pc` = `fetch_pc`+4.
- R8: A store in slot 1 followed by any load or store in slot 2 causes a split. A load followed by a store, or a store followed by a non-memory word, may dual-issue.
- R9: Halt in slot 1. A word with bits [31:28] = 0xF in slot 1 issues alone on way 1 and makes `next_pc` = `fetch_pc`. The machine then moves to HALTED and `halted` is 1. In HALTED nothing issues, and `next_pc` = `fetch_pc` until reset.
- R10: A halt word in slot 2 causes a split, so it leads the next pair.
- R11: While `fetch_valid` is low, nothing issues at the next edge and `next_pc` = `fetch_pc`.
- R12: A way that does not issue carries the all-zero word with its valid bit at 0.
- R13: Shifts sll (funct 0x00) and srl (funct 0x02) read only rs. A match on their rt field causes no split.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Slot words are meaningful this cycle |
| fetch_pc | input | 32 | Address of the slot 1 word |
| slot1_word | input | 32 | Leading fetched instruction |
| slot2_word | input | 32 | Trailing fetched instruction (address + 4) |
| next_pc | output | 32 | Next fetch address (combinational) |
| way1_word | output | 32 | Registered word issued on way 1 |
| way1_valid | output | 1 | Way 1 carries a real instruction |
| way2_word | output | 32 | Registered word issued on way 2 |
| way2_valid | output | 1 | Way 2 carries a real instruction |
| pair_dual | output | 1 | Both ways issued this pair |
| halted | output | 1 | Machine is in HALTED |

## Verification
The bench targets register-0 writes and sll/srl carrying a stray rt field:
- A design that treats register 0 as a real destination splits pairs it could issue together.
- A design that ignores the field rules lets a dependent pair through.
- A design that sends a shift's unused rt field to the comparator stalls needlessly.

It also checks the fetch-address choice, because fetch relies on it. A branch in either slot or a halt must never advance by 8. A halt in slot 1 must hold the address, not step by 4. A design that got any of these wrong would skip or re-execute an instruction. Finally, the bench drives more pairs after a halt to show that the HALTED state never issues again.

// File: rtl/pair_scheduler_pkg.sv
package pair_scheduler_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned REG_W   = 5;
    localparam logic [REG_W-1:0] LINK_REG = 5'd31;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_JUMP  = 6'h02;
    localparam logic [5:0] OP_JLINK = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;

    localparam logic [5:0] FN_SLL = 6'h00;
    localparam logic [5:0] FN_SRL = 6'h02;
    localparam logic [5:0] FN_JR  = 6'h08;
    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_SLT = 6'h2A;

    localparam logic [3:0] HALT_TAG = 4'hF;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_HALTED
    } sched_state_e;

    typedef enum logic [1:0] {
        ADV_HOLD,
        ADV_ONE,
        ADV_TWO
    } fetch_adv_e;

    typedef struct packed {
        logic             wr_en;
        logic [REG_W-1:0] wr_reg;
        logic             rs_use;
        logic [REG_W-1:0] rs;
        logic             rt_use;
        logic [REG_W-1:0] rt;
        logic             is_ctrl;
        logic             is_mem;
        logic             is_store;
        logic             is_halt;
    } ifields_t;

    function automatic logic is_ctrl_word(input logic [WORD_W-1:0] w);
        logic hit;
        hit = 1'b0;
        if (w[31:28] != HALT_TAG) begin
            if (w[31:26] == OP_JUMP || w[31:26] == OP_JLINK || w[31:26] == OP_BEQ)
                hit = 1'b1;
            if (w[31:26] == OP_RTYPE && w[5:0] == FN_JR)
                hit = 1'b1;
        end
        return hit;
    endfunction

endpackage

// File: rtl/pair_scheduler_decode.sv
module pair_scheduler_decode
    import pair_scheduler_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output ifields_t          fields
);

    logic [5:0]       opc;
    logic [5:0]       fn;
    logic [REG_W-1:0] f_rs;
    logic [REG_W-1:0] f_rt;
    logic [REG_W-1:0] f_rd;
    logic             unused_shamt;

    assign opc          = word[31:26];
    assign fn           = word[5:0];
    assign f_rs         = word[25:21];
    assign f_rt         = word[20:16];
    assign f_rd         = word[15:11];
    assign unused_shamt = ^word[10:6];

    always_comb begin
        logic             wants_wr;
        logic [REG_W-1:0] dst;
        fields   = '0;
        wants_wr = 1'b0;
        dst      = '0;
        fields.rs = f_rs;
        fields.rt = f_rt;
        if (word[31:28] == HALT_TAG) begin
            fields.is_halt = 1'b1;
        end else begin
            case (opc)
                OP_RTYPE: begin
                    case (fn)
                        FN_ADD, FN_SUB, FN_AND, FN_OR, FN_XOR, FN_SLT: begin
                            fields.rs_use = 1'b1;
                            fields.rt_use = 1'b1;
                            wants_wr      = 1'b1;
                            dst           = f_rd;
                        end
                        FN_SLL, FN_SRL: begin
                            fields.rs_use = 1'b1;
                            wants_wr      = 1'b1;
                            dst           = f_rd;
                        end
                        FN_JR: begin
                            fields.rs_use  = 1'b1;
                            fields.is_ctrl = 1'b1;
                        end
                        default: ;
                    endcase
                end
                OP_ADDI: begin
                    fields.rs_use = 1'b1;
                    wants_wr      = 1'b1;
                    dst           = f_rt;
                end
                OP_LOAD: begin
                    fields.rs_use = 1'b1;
                    fields.is_mem = 1'b1;
                    wants_wr      = 1'b1;
                    dst           = f_rt;
                end
                OP_STORE: begin
                    fields.rs_use   = 1'b1;
                    fields.rt_use   = 1'b1;
                    fields.is_mem   = 1'b1;
                    fields.is_store = 1'b1;
                end
                OP_BEQ: begin
                    fields.rs_use  = 1'b1;
                    fields.rt_use  = 1'b1;
                    fields.is_ctrl = 1'b1;
                end
                OP_JUMP: begin
                    fields.is_ctrl = 1'b1;
                end
                OP_JLINK: begin
                    fields.is_ctrl = 1'b1;
                    wants_wr       = 1'b1;
                    dst            = LINK_REG;
                end
                default: ;
            endcase
        end
        fields.wr_reg = dst;
        fields.wr_en  = wants_wr && (dst != '0);
    end

endmodule

// File: rtl/pair_scheduler_hazard.sv
module pair_scheduler_hazard
    import pair_scheduler_pkg::*;
(
    input  ifields_t   lead,
    input  ifields_t   trail,
    output logic       split,
    output fetch_adv_e adv
);

    logic raw_hit;
    logic waw_hit;
    logic mem_order;
    logic ctrl_block;
    logic unused_fields;

    assign unused_fields = ^{lead.rs_use, lead.rs, lead.rt_use, lead.rt, trail.is_store};

    always_comb begin
        raw_hit = lead.wr_en &&
                  ((trail.rs_use && trail.rs == lead.wr_reg) ||
                   (trail.rt_use && trail.rt == lead.wr_reg));
        waw_hit    = lead.wr_en && trail.wr_en && (trail.wr_reg == lead.wr_reg);
        mem_order  = lead.is_store && trail.is_mem;
        ctrl_block = lead.is_ctrl || lead.is_halt || trail.is_ctrl || trail.is_halt;
        split      = raw_hit || waw_hit || mem_order || ctrl_block;
        if (lead.is_halt)
            adv = ADV_HOLD;
        else if (split)
            adv = ADV_ONE;
        else
            adv = ADV_TWO;
    end

endmodule

// File: rtl/pair_scheduler.sv
module pair_scheduler
    import pair_scheduler_pkg::*;
#(
    parameter int unsigned INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [WORD_W-1:0] fetch_pc,
    input  logic [WORD_W-1:0] slot1_word,
    input  logic [WORD_W-1:0] slot2_word,
    output logic [WORD_W-1:0] next_pc,
    output logic [WORD_W-1:0] way1_word,
    output logic              way1_valid,
    output logic [WORD_W-1:0] way2_word,
    output logic              way2_valid,
    output logic              pair_dual,
    output logic              halted
);

    localparam int unsigned WAYS = 2;
    localparam logic [WORD_W-1:0] STEP_ONE = WORD_W'(INSTR_BYTES);
    localparam logic [WORD_W-1:0] STEP_TWO = WORD_W'(2 * INSTR_BYTES);

    sched_state_e      state_q;
    sched_state_e      state_d;
    logic [WORD_W-1:0] slot_word [WAYS];
    ifields_t          dec [WAYS];
    logic              split;
    fetch_adv_e        adv;
    logic              accept;

    assign slot_word[0] = slot1_word;
    assign slot_word[1] = slot2_word;

    for (genvar g = 0; g < WAYS; g++) begin : g_dec
        pair_scheduler_decode u_dec (
            .word   (slot_word[g]),
            .fields (dec[g])
        );
    end

    pair_scheduler_hazard u_haz (
        .lead  (dec[0]),
        .trail (dec[1]),
        .split (split),
        .adv   (adv)
    );

    assign accept = fetch_valid && (state_q == ST_RUN);
    assign halted = (state_q == ST_HALTED);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_RUN;
        else
            state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (fetch_valid && dec[0].is_halt) state_d = ST_HALTED;
            ST_HALTED: state_d = ST_HALTED;
        endcase
    end

    // fetch address
    always_comb begin
        next_pc = fetch_pc;
        if (accept) begin
            unique case (adv)
                ADV_HOLD: next_pc = fetch_pc;
                ADV_ONE:  next_pc = fetch_pc + STEP_ONE;
                ADV_TWO:  next_pc = fetch_pc + STEP_TWO;
                default:  next_pc = fetch_pc;
            endcase
        end
    end

    // issue registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            way1_word  <= '0;
            way1_valid <= 1'b0;
            way2_word  <= '0;
            way2_valid <= 1'b0;
            pair_dual  <= 1'b0;
        end else if (accept) begin
            way1_word  <= slot1_word;
            way1_valid <= 1'b1;
            way2_word  <= split ? '0 : slot2_word;
            way2_valid <= !split;
            pair_dual  <= !split;
        end else begin
            way1_word  <= '0;
            way1_valid <= 1'b0;
            way2_word  <= '0;
            way2_valid <= 1'b0;
            pair_dual  <= 1'b0;
        end
    end

    AST_WAY2_NEEDS_WAY1: assert property (@(posedge clk) disable iff (!rst_n)
        way2_valid |-> way1_valid); // R2

    AST_IDLE_WAY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !way2_valid |-> (way2_word == '0)); // R12

    AST_NO_CTRL_WAY2: assert property (@(posedge clk) disable iff (!rst_n)
        way2_valid |-> !is_ctrl_word(way2_word)); // R6

    AST_HALT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9

    AST_HALTED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> !way1_valid); // R9

    AST_IDLE_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_valid |=> !way1_valid); // R11

endmodule

// File: tb/pair_scheduler_test.sv
`timescale 1ns/1ps
module pair_scheduler_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_valid = 1'b0;
    logic [31:0] fetch_pc = 32'h0;
    logic [31:0] slot1_word = 32'h0;
    logic [31:0] slot2_word = 32'h0;
    logic [31:0] next_pc;
    logic [31:0] way1_word;
    logic        way1_valid;
    logic [31:0] way2_word;
    logic        way2_valid;
    logic        pair_dual;
    logic        halted;

    int checks = 0;
    int failures = 0;
    bit model_halted = 1'b0;

    always #2.5 clk = ~clk;

    pair_scheduler uut (
        .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .slot1_word(slot1_word), .slot2_word(slot2_word), .next_pc(next_pc),
        .way1_word(way1_word), .way1_valid(way1_valid), .way2_word(way2_word),
        .way2_valid(way2_valid), .pair_dual(pair_dual), .halted(halted)
    );

    function automatic logic [31:0] enc_r(input int fn, input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
    endfunction
    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {6'(op), 26'(tgt)};
    endfunction

    // reference: register sets as bit masks
    function automatic bit is_halt_w(input logic [31:0] w);
        return w[31:28] == 4'hF;
    endfunction
    function automatic logic [31:0] reads_of(input logic [31:0] w);
        logic [31:0] m = 0;
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        if (is_halt_w(w)) return 0;
        if (op == 0) begin
            if (fn == 'h20 || fn == 'h22 || fn == 'h24 || fn == 'h25 || fn == 'h26 || fn == 'h2A) begin
                m[w[25:21]] = 1; m[w[20:16]] = 1;
            end else if (fn == 0 || fn == 2 || fn == 8) m[w[25:21]] = 1;
        end else if (op == 'h08 || op == 'h23) m[w[25:21]] = 1;
        else if (op == 'h2B || op == 'h04) begin m[w[25:21]] = 1; m[w[20:16]] = 1; end
        return m;
    endfunction
    function automatic logic [31:0] writes_of(input logic [31:0] w);
        logic [31:0] m = 0;
        int op = int'(w[31:26]);
        int fn = int'(w[5:0]);
        if (is_halt_w(w)) return 0;
        if (op == 0 && fn != 8 && (fn == 0 || fn == 2 || fn >= 'h20)) m[w[15:11]] = 1;
        if (op == 0 && !(fn == 0 || fn == 2 || fn == 'h20 || fn == 'h22 || fn == 'h24 ||
                         fn == 'h25 || fn == 'h26 || fn == 'h2A)) m = 0;
        if (op == 'h08 || op == 'h23) m[w[20:16]] = 1;
        if (op == 'h03) m[31] = 1;
        m[0] = 0;
        return m;
    endfunction
    function automatic bit is_xfer(input logic [31:0] w);
        if (is_halt_w(w)) return 0;
        return w[31:26] == 6'h02 || w[31:26] == 6'h03 || w[31:26] == 6'h04 ||
               (w[31:26] == 6'h00 && w[5:0] == 6'h08);
    endfunction
    function automatic bit is_memop(input logic [31:0] w);
        return !is_halt_w(w) && (w[31:26] == 6'h23 || w[31:26] == 6'h2B);
    endfunction
    function automatic bit is_st(input logic [31:0] w);
        return !is_halt_w(w) && w[31:26] == 6'h2B;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive one pair, compare next_pc before the edge and registered outputs after it
    task automatic step(input string tag, input bit fv, input logic [31:0] pc,
                        input logic [31:0] a, input logic [31:0] b);
        bit split;
        logic [31:0] exp_pc;
        bit issue;
        @(negedge clk);
        fetch_valid = fv; fetch_pc = pc; slot1_word = a; slot2_word = b;
        #1;
        issue = fv && !model_halted;
        split = is_xfer(a) || is_xfer(b) || is_halt_w(a) || is_halt_w(b) ||
                ((writes_of(a) & (reads_of(b) | writes_of(b))) != 0) ||
                (is_st(a) && is_memop(b));
        if (!issue) exp_pc = pc;
        else if (is_halt_w(a)) exp_pc = pc;
        else if (split) exp_pc = pc + 4;
        else exp_pc = pc + 8;
        chk(tag, "next_pc", next_pc, exp_pc);
        @(posedge clk);
        #1;
        if (issue && is_halt_w(a)) model_halted = 1'b1;
        chk(tag, "way1_valid", 32'(way1_valid), 32'(issue));
        chk(tag, "way1_word", way1_word, issue ? a : 32'h0);
        chk(tag, "way2_valid", 32'(way2_valid), 32'(issue && !split));
        chk(tag, "way2_word", way2_word, (issue && !split) ? b : 32'h0);
        chk(tag, "pair_dual", 32'(pair_dual), 32'(issue && !split));
        chk(tag, "halted", 32'(halted), 32'(model_halted));
    endtask

    initial begin
        repeat (1000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fetch_pc = 32'h100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "way1_valid", 32'(way1_valid), 0);
        chk("R1", "way2_valid", 32'(way2_valid), 0);
        chk("R1", "pair_dual", 32'(pair_dual), 0);
        chk("R1", "halted", 32'(halted), 0);
        chk("R1", "way1_word", way1_word, 0);
        chk("R1", "next_pc", next_pc, 32'h100);
        rst_n = 1'b1;

        step("R2", 1, 32'h100, enc_r('h20, 1, 2, 3), enc_r('h22, 4, 5, 6));
        step("R2", 1, 32'h108, enc_i('h08, 1, 7, 5), enc_r('h26, 2, 4, 8));
        step("R3", 1, 32'h110, enc_r('h20, 1, 2, 3), enc_r('h24, 3, 4, 7));
        step("R3", 1, 32'h114, enc_i('h08, 1, 5, 9), enc_r('h25, 2, 5, 8));
        step("R3", 1, 32'h118, enc_i('h23, 1, 6, 0), enc_i('h2B, 2, 6, 4));
        step("R3", 1, 32'h11C, enc_r('h2A, 1, 2, 12), enc_r(8, 12, 0, 0));
        step("R4", 1, 32'h120, enc_i('h23, 1, 9, 0), enc_i('h08, 2, 9, 1));
        step("R4", 1, 32'h124, enc_r('h20, 1, 2, 10), enc_i('h23, 3, 10, 8));
        step("R4", 1, 32'h128, enc_r('h20, 1, 2, 11), enc_r('h22, 3, 4, 11));
        step("R4", 1, 32'h12C, enc_r('h20, 1, 2, 3), enc_r('h20, 4, 5, 3 + 8));
        step("R5", 1, 32'h130, enc_r('h20, 1, 2, 0), enc_r('h20, 0, 0, 4));
        step("R5", 1, 32'h138, enc_i('h08, 1, 0, 3), enc_i('h08, 2, 0, 7));
        step("R13", 1, 32'h140, enc_i('h08, 1, 7, 2), enc_r(0, 2, 7, 5));
        step("R13", 1, 32'h148, enc_i('h08, 1, 7, 2), enc_r(2, 3, 7, 6));
        step("R13", 1, 32'h150, enc_i('h08, 1, 7, 2), enc_r(2, 7, 0, 6));
        step("R6", 1, 32'h154, enc_r('h20, 1, 2, 3), enc_i('h04, 4, 5, 16));
        step("R6", 1, 32'h158, enc_r('h20, 1, 2, 3), enc_j('h02, 64));
        step("R6", 1, 32'h15C, enc_r('h20, 1, 2, 3), enc_r(8, 9, 0, 0));
        step("R7", 1, 32'h160, enc_i('h04, 1, 2, 8), enc_r('h20, 4, 5, 6));
        step("R7", 1, 32'h164, enc_j('h03, 80), enc_r('h20, 31, 1, 4));
        step("R7", 1, 32'h168, enc_j('h02, 90), enc_r('h20, 4, 5, 6));
        step("R8", 1, 32'h16C, enc_i('h2B, 1, 2, 0), enc_i('h23, 3, 4, 0));
        step("R8", 1, 32'h170, enc_i('h2B, 1, 2, 0), enc_i('h2B, 3, 4, 8));
        step("R8", 1, 32'h174, enc_i('h23, 1, 2, 0), enc_i('h2B, 3, 4, 0));
        step("R8", 1, 32'h17C, enc_i('h2B, 1, 2, 0), enc_r('h20, 3, 4, 5));
        step("R11", 0, 32'h184, enc_r('h20, 1, 2, 3), enc_r('h20, 4, 5, 6));
        step("R12", 1, 32'h184, enc_r('h20, 1, 2, 3), enc_r('h20, 3, 3, 3));
        step("R10", 1, 32'h188, enc_r('h20, 1, 2, 3), 32'hF123_4567);
        step("R9", 1, 32'h18C, 32'hFFFF_FFFF, enc_r('h20, 1, 2, 3));
        step("R9", 1, 32'h18C, enc_r('h20, 1, 2, 3), enc_r('h20, 4, 5, 6));
        step("R9", 1, 32'h200, enc_i('h08, 1, 2, 3), enc_i('h08, 4, 5, 6));

        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        model_halted = 1'b0;
        chk("R1", "halted", 32'(halted), 0);
        @(negedge clk);
        rst_n = 1'b1;
        step("R2", 1, 32'h0, enc_r('h20, 1, 2, 3), enc_r('h22, 4, 5, 6));

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule